// File: doc/BRIEF.md
# Width-switchable static memory core

This block is a synthesizable functional model of a static memory that can be used either as 16-bit words or as 8-bit bytes. A strap input chooses the organisation and may change from one clock to the next. The memory has two chip enables: one is active low and one is active high. It also has an active-low write enable, an active-low output enable, two active-low byte-lane strobes, and one extra address input that is used only in byte mode. The data bus is split into an input vector, an output vector and a per-bit output-enable vector, so that the bidirectional pad can sit outside the block.

All pins are sampled on the rising edge of the system clock. A decoder turns each sampled pin set into one of four operation states: `ST_OFF` (deselected), `ST_HOLD` (selected, outputs disabled), `ST_READ` and `ST_WRITE`. Every clock the state register loads the decoded state, so the machine can go from any state to any state. The transitions are named by their cause:
- deselect goes to `ST_OFF`;
- write-strobe goes to `ST_WRITE`;
- read-strobe goes to `ST_READ`;
- park goes to `ST_HOLD`.

A write is stored at the same edge at which it is sampled. Read data and output enables come from registers and appear in the cycle after the pins were sampled.

The depth is set by the word-address width. In byte mode the extra address input is the least significant bit of the byte address. A 0 on it selects the low half (bits 7:0) of the word, and a 1 selects the high half (bits 15:8).

Top module: `dual_width_sram`

## Requirements
- R1: The part is selected only when `cs1_n`=0 and `cs2`=1. Otherwise the next cycle shows `dq_oe`=0 and `dq_out`=0, and no location is written.
- R2: With `width_sel`=1 (word mode), `addr` selects one 16-bit word and `byte_lsb` has no effect on reads or writes.
- R3: With `width_sel`=0 (byte mode), the byte address is {`addr`,`byte_lsb`}. `byte_lsb`=0 maps to bits 7:0 of word `addr` and 1 maps to bits 15:8. A byte write changes only that half. Byte data uses `dq_in[7:0]` and `dq_out[7:0]`, and `dq_oe[15:8]` stays 0.
- R4: In word mode with `lane_lo_n`=1 and `lane_hi_n`=1 the part behaves as deselected: no drive and no write.
- R5: A read (selected, `we_n`=1, `oe_n`=0) shows the stored data in the next cycle. In word mode `lane_lo_n`=0 sets `dq_oe[7:0]`=8'hFF with bits 7:0 of the word. Independently, `lane_hi_n`=0 sets `dq_oe[15:8]`=8'hFF with bits 15:8.
- R6: A selected cycle with `we_n`=0 writes at that clock edge, whatever `oe_n` is. In word mode only the lanes whose strobe is 0 are updated, lane 0 from `dq_in[7:0]` and lane 1 from `dq_in[15:8]`. In the next cycle `dq_oe`=0.
- R7: A selected cycle with `we_n`=1 and `oe_n`=1 gives `dq_oe`=0 and `dq_out`=0 in the next cycle.
- R8: In byte mode the lane strobes are don't-care for both reads and writes.
- R9: `dq_out` bits whose `dq_oe` bit is 0 read 0. After the asynchronous active-low reset, `dq_oe`=0 and `dq_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; pins sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| width_sel | input | 1 | 1 = 16-bit word mode, 0 = 8-bit byte mode |
| lane_lo_n | input | 1 | Lower lane strobe (bits 7:0), active low, word mode only |
| lane_hi_n | input | 1 | Upper lane strobe (bits 15:8), active low, word mode only |
| byte_lsb | input | 1 | Byte-address least significant bit, byte mode only |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data from the pad |
| dq_out | output | 16 | Data to the pad |
| dq_oe | output | 16 | Per-bit pad drive enable |

## Verification
The assertions assume that every pin is stable and known at each rising clock edge. They also assume that the array is read only at addresses already written, because an unwritten location carries no defined value. The stimulus meets both conditions:
- it drives every pin from a single process at the falling edge;
- it first fills every word of the array in word mode;
- its pseudo-random phase draws only whole, known pin sets.

From then on, any mix of modes, strobes and enables is legal. The reference model follows it cycle by cycle.

// File: rtl/dws_pkg.sv
package dws_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_HOLD  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } dws_state_e;
endpackage

// File: rtl/dws_decode.sv
module dws_decode
    import dws_pkg::*;
(
    input  logic       cs1_n,
    input  logic       cs2,
    input  logic       we_n,
    input  logic       oe_n,
    input  logic       width_sel,
    input  logic       lane_lo_n,
    input  logic       lane_hi_n,
    input  logic       byte_lsb,
    output dws_state_e next_state,
    output logic [1:0] bank_we,
    output logic [1:0] out_lanes
);
    logic       chip_on;
    logic       selected;
    logic [1:0] bank_mask;

    // Which 8-bit bank is addressed: strobes in word mode, half select in byte mode
    always_comb begin
        if (width_sel) begin
            bank_mask = {~lane_hi_n, ~lane_lo_n};
        end else begin
            bank_mask = {byte_lsb, ~byte_lsb};
        end
    end

    assign chip_on  = !cs1_n && cs2;
    assign selected = chip_on && (bank_mask != 2'b00);

    always_comb begin
        if (!selected) begin
            next_state = ST_OFF;     // deselect
        end else if (!we_n) begin
            next_state = ST_WRITE;   // write-strobe
        end else if (!oe_n) begin
            next_state = ST_READ;    // read-strobe
        end else begin
            next_state = ST_HOLD;    // park
        end
    end

    assign bank_we   = (next_state == ST_WRITE) ? bank_mask : 2'b00;
    // Byte mode always presents its byte on the low lane
    assign out_lanes = width_sel ? bank_mask : 2'b01;
endmodule

// File: rtl/dws_array.sv
module dws_array #(
    parameter int ADDR_W = 8,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic [LANES-1:0]          bank_we,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (bank_we[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[addr];
    end
endmodule

// File: rtl/dws_outstage.sv
module dws_outstage
    import dws_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  dws_state_e              next_state,
    input  logic [LANES-1:0]        out_lanes,
    input  logic [LANES*LANE_W-1:0] rd_word,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic [LANES*LANE_W-1:0] dq_oe
);
    localparam int DW = LANES * LANE_W;

    dws_state_e       state_q;
    logic [LANES-1:0] lanes_q;
    logic [DW-1:0]    data_q;

    // State register: loads the decoded operation every clock
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            lanes_q <= '0;
            data_q  <= '0;
        end else begin
            state_q <= next_state;
            lanes_q <= out_lanes;
            data_q  <= rd_word;
        end
    end

    // Output process
    always_comb begin
        dq_oe  = '0;
        dq_out = '0;
        unique case (state_q)
            ST_READ: begin
                for (int i = 0; i < LANES; i++) begin
                    dq_oe[i*LANE_W +: LANE_W]  = {LANE_W{lanes_q[i]}};
                    dq_out[i*LANE_W +: LANE_W] = lanes_q[i] ? data_q[i*LANE_W +: LANE_W] : '0;
                end
            end
            ST_OFF, ST_HOLD, ST_WRITE: begin
                dq_oe  = '0;
                dq_out = '0;
            end
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        AST_LANE_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
            (dq_oe[g*LANE_W +: LANE_W] == '0) || (dq_oe[g*LANE_W +: LANE_W] == '1)); // R5
        AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (dq_oe[g*LANE_W +: LANE_W] == '0) |-> (dq_out[g*LANE_W +: LANE_W] == '0)); // R9
    end
endmodule

// File: rtl/dual_width_sram.sv
module dual_width_sram
    import dws_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              width_sel,
    input  logic              lane_lo_n,
    input  logic              lane_hi_n,
    input  logic              byte_lsb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe
);
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DW     = LANE_W * LANES;

    dws_state_e       next_state;
    logic [LANES-1:0] bank_we;
    logic [LANES-1:0] out_lanes;
    logic [DW-1:0]    wdata;
    logic [DW-1:0]    rdata;
    logic [DW-1:0]    rd_steer;

    dws_decode u_decode (
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .width_sel  (width_sel),
        .lane_lo_n  (lane_lo_n),
        .lane_hi_n  (lane_hi_n),
        .byte_lsb   (byte_lsb),
        .next_state (next_state),
        .bank_we    (bank_we),
        .out_lanes  (out_lanes)
    );

    // Byte mode feeds the low data lane into whichever bank is addressed
    assign wdata = {(width_sel ? dq_in[15:8] : dq_in[7:0]), dq_in[7:0]};

    dws_array #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_array (
        .clk     (clk),
        .bank_we (bank_we),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    // Byte mode brings the addressed half down to the low lane
    always_comb begin
        if (width_sel) begin
            rd_steer = rdata;
        end else begin
            rd_steer = {{LANE_W{1'b0}}, (byte_lsb ? rdata[DW-1:LANE_W] : rdata[LANE_W-1:0])};
        end
    end

    dws_outstage #(
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .next_state (next_state),
        .out_lanes  (out_lanes),
        .rd_word    (rd_steer),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs1_n || !cs2) |=> (dq_oe == 16'h0000)); // R1
    AST_BYTE_HI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !width_sel |=> (dq_oe[15:8] == 8'h00)); // R3
    AST_STROBES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (width_sel && lane_lo_n && lane_hi_n) |=> (dq_oe == 16'h0000)); // R4
    AST_RD_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs1_n && cs2 && we_n && !oe_n && width_sel && !lane_lo_n) |=> (dq_oe[7:0] == 8'hFF)); // R5
    AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> (dq_oe == 16'h0000)); // R6
    AST_OUT_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && oe_n) |=> (dq_oe == 16'h0000)); // R7
    AST_BYTE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs1_n && cs2 && we_n && !oe_n && !width_sel) |=> (dq_oe == 16'h00FF)); // R8
endmodule

// File: tb/dual_width_sram_test.sv
module dual_width_sram_test;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs1_n = 1'b1, cs2 = 1'b0, we_n = 1'b1, oe_n = 1'b1;
    logic          width_sel = 1'b1, lane_lo_n = 1'b1, lane_hi_n = 1'b1, byte_lsb = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   dq_in = '0;
    logic [15:0]   dq_out, dq_oe;

    int vectors = 0;
    int misses  = 0;
    bit finished = 0;
    logic [15:0] model_mem [DEPTH];
    logic [15:0] exp_out, exp_oe;
    logic [31:0] rng = 32'h1234_5679;

    always #10 clk = ~clk;

    dual_width_sram #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .we_n(we_n), .oe_n(oe_n),
        .width_sel(width_sel), .lane_lo_n(lane_lo_n), .lane_hi_n(lane_hi_n),
        .byte_lsb(byte_lsb), .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input string tag, input logic c1n, input logic c2, input logic wen,
                       input logic oen, input logic ws, input logic lon, input logic hin,
                       input logic bl, input logic [AW-1:0] a, input logic [15:0] d);
        bit sel;
        cs1_n = c1n; cs2 = c2; we_n = wen; oe_n = oen; width_sel = ws;
        lane_lo_n = lon; lane_hi_n = hin; byte_lsb = bl; addr = a; dq_in = d;
        @(posedge clk);
        sel = !c1n && c2 && (!ws || !(lon && hin));
        exp_out = '0;
        exp_oe  = '0;
        if (sel && wen && !oen) begin
            if (ws) begin
                if (!lon) begin exp_oe[7:0]  = 8'hFF; exp_out[7:0]  = model_mem[a][7:0];  end
                if (!hin) begin exp_oe[15:8] = 8'hFF; exp_out[15:8] = model_mem[a][15:8]; end
            end else begin
                exp_oe[7:0]  = 8'hFF;
                exp_out[7:0] = bl ? model_mem[a][15:8] : model_mem[a][7:0];
            end
        end
        if (sel && !wen) begin
            if (ws) begin
                if (!lon) model_mem[a][7:0]  = d[7:0];
                if (!hin) model_mem[a][15:8] = d[15:8];
            end else if (bl) begin
                model_mem[a][15:8] = d[7:0];
            end else begin
                model_mem[a][7:0] = d[7:0];
            end
        end
        @(negedge clk);
        check({tag, " dq_oe"}, dq_oe, exp_oe);
        check({tag, " dq_out"}, dq_out, exp_out);
    endtask

    task automatic wr_w(input string tag, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic lon = 0, input logic hin = 0, input logic oen = 1);
        cyc(tag, 0, 1, 0, oen, 1, lon, hin, 0, a, d);
    endtask
    task automatic rd_w(input string tag, input logic [AW-1:0] a,
                        input logic lon = 0, input logic hin = 0, input logic bl = 0);
        cyc(tag, 0, 1, 1, 0, 1, lon, hin, bl, a, 16'hDEAD);
    endtask
    task automatic wr_b(input string tag, input logic [AW-1:0] a, input logic bl,
                        input logic [7:0] d, input logic lon = 0, input logic hin = 0);
        cyc(tag, 0, 1, 0, 1, 0, lon, hin, bl, a, {8'h5C, d});
    endtask
    task automatic rd_b(input string tag, input logic [AW-1:0] a, input logic bl,
                        input logic lon = 0, input logic hin = 0);
        cyc(tag, 0, 1, 1, 0, 0, lon, hin, bl, a, 16'hBEEF);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset dq_oe", dq_oe, 16'h0000);
        check("R9 reset dq_out", dq_out, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        // Fill every word in word mode (R6, R2); byte_lsb ignored
        for (int i = 0; i < DEPTH; i++) begin
            cyc("R2 fill", 0, 1, 0, 1, 1, 0, 0, i[0], i[AW-1:0], 16'hA55A ^ (i[15:0] * 16'h0101));
        end
        // Word reads with each strobe pattern; byte_lsb toggled (R2, R5, R4)
        rd_w("R5 both lanes", 8'h10);
        rd_w("R5 low lane", 8'h11, 0, 1);
        rd_w("R5 high lane", 8'h12, 1, 0);
        rd_w("R4 no strobe read", 8'h13, 1, 1);
        rd_w("R2 lsb ignored", 8'h10, 0, 0, 1);
        // Deselect cases with write attempts, then read back (R1)
        cyc("R1 cs1 high", 1, 1, 0, 1, 1, 0, 0, 0, 8'h20, 16'h1111);
        cyc("R1 cs2 low", 0, 0, 0, 1, 1, 0, 0, 0, 8'h20, 16'h2222);
        cyc("R1 both off", 1, 0, 0, 1, 1, 0, 0, 0, 8'h20, 16'h3333);
        cyc("R1 read off", 1, 0, 1, 0, 1, 0, 0, 0, 8'h20, 16'h0);
        cyc("R1 byte off", 1, 1, 1, 0, 0, 0, 0, 0, 8'h20, 16'h0);
        rd_w("R1 readback", 8'h20);
        // Word mode with both strobes off: no write (R4)
        wr_w("R4 no strobe write", 8'h21, 16'hFFFF, 1, 1);
        rd_w("R4 readback", 8'h21);
        // Partial-lane writes and write with oe_n low (R6)
        wr_w("R6 low lane only", 8'h22, 16'h1234, 0, 1);
        wr_w("R6 high lane only", 8'h23, 16'h5678, 1, 0);
        wr_w("R6 write oe low", 8'h24, 16'h9ABC, 0, 0, 0);
        rd_w("R6 readback low", 8'h22);
        rd_w("R6 readback high", 8'h23);
        rd_w("R6 readback oe", 8'h24);
        // Output disable (R7)
        cyc("R7 output disable", 0, 1, 1, 1, 1, 0, 0, 0, 8'h24, 16'h0);
        cyc("R7 byte disable", 0, 1, 1, 1, 0, 0, 0, 1, 8'h24, 16'h0);
        // Byte mode: writes into each half, cross-mode readback (R3)
        wr_b("R3 byte lo", 8'h30, 0, 8'h3C);
        wr_b("R3 byte hi", 8'h31, 1, 8'hC3);
        rd_w("R3 word sees lo", 8'h30);
        rd_w("R3 word sees hi", 8'h31);
        rd_b("R3 byte read lo", 8'h24, 0);
        rd_b("R3 byte read hi", 8'h24, 1);
        // Byte mode with strobes off or mixed (R8)
        wr_b("R8 strobes off write", 8'h32, 1, 8'h77, 1, 1);
        rd_b("R8 strobes off read", 8'h32, 1, 1, 1);
        rd_b("R8 mixed strobes", 8'h32, 0, 1, 0);
        rd_w("R8 word readback", 8'h32);

        // Mixed pseudo-random traffic across both modes
        for (int n = 0; n < 3000; n++) begin
            rng = rng ^ (rng << 13);
            rng = rng ^ (rng >> 17);
            rng = rng ^ (rng << 5);
            cyc("R3 R5 R6 mix", (rng[2:0] == 3'd0), (rng[5:3] != 3'd0), rng[6], rng[7],
                rng[8], rng[9], rng[10], rng[11], rng[19:12], rng[31:16]);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule